// File: doc/BRIEF.md
# Anti-shock audio buffer controller

This block sits between the disc acquisition path and audio playback and keeps a large circular buffer of raw frames in an external memory. Each frame is 32 symbols taken before error correction, parity symbols included, so every symbol of every frame is stored. Frames arrive in bursts at an irregular rate and are written ahead of playback. A fixed-rate slot strobe pulls symbols back out one at a time, with a constant latency of one slot, so the output carries no jitter from the input side.

The external memory has a single word-addressed port with a ready signal. The block holds a write pointer, a read pointer and an arbiter that shares this one port between them. Writes have priority. A read that has waited a bounded number of cycles is promoted ahead of writes, so each slot's fetch always completes before the next slot.

A small byte-wide register port lets software preset the write pointer, read the fill level and the position of the newest clean frame, and reset both pointers by reading a dummy location. This is enough to resynchronize after a mechanical shock. An overflow interrupt flags frames that were dropped because the buffer was full.

Top module: `shockbuf_ctrl`

## Requirements
- R1: After reset the fill level is 0, `ovf_irq` is 0, the last-valid frame reads 0, and the first symbol delivered after reset has `out_invalid` set.
- R2: Every `out_slot` pulse gives an `out_valid` pulse exactly one cycle later. That pulse carries the symbol fetched at the previous slot, so playback runs in order, one symbol per slot.
- R3: The memory port serves writes before reads, and `in_ready` is low while `mem_ready` is low. A pending read that has waited `MAX_WAIT` cycles takes the port ahead of any write.
- R4: Symbol k of a frame held in frame slot p is written at memory address p*32+k (frame slot in the upper address bits, symbol index in the lower 5). All 32 symbols are written in arrival order.
- R5: The fill level is the count of completed frames minus the count of fully read frames, modulo `NFRM`. It reads as a 16-bit value at register 4 (low byte) and register 5 (high byte).
- R6: If the first symbol of a frame arrives while the level is `NFRM-1`, the whole frame is accepted without any memory write, the level stays unchanged, and `ovf_irq` is set. `ovf_irq` then stays set.
- R7: Register 2 (low byte) and register 3 (high byte) give the frame slot of the latest frame whose 32 symbols were all written with `in_err` low. A frame with any flagged symbol leaves this value unchanged.
- R8: At a slot where the level is 0, no memory read is started, and the symbol delivered at the next slot has `out_invalid` set and `out_sym` equal to 0.
- R9: Writing register 0 and then register 1 loads the write frame pointer from {reg1 data, reg0 data} and restarts the symbol count. Registers 0 and 1 read back the write frame pointer.
- R10: A read of register 6 returns 0 and resets both frame pointers, both symbol counters, any pending read and `ovf_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming symbol present |
| in_sym | input | DW | Incoming symbol |
| in_err | input | 1 | Sync error flag for the incoming symbol |
| in_ready | output | 1 | Incoming symbol accepted this cycle |
| out_slot | input | 1 | Fixed-rate playback strobe |
| out_valid | output | 1 | Delivered symbol present |
| out_sym | output | DW | Delivered symbol |
| out_invalid | output | 1 | Delivered symbol is underflow filler |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | FW+SW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid the cycle after an accepted read |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ovf_irq | output | 1 | Sticky overflow interrupt |

## Verification
The assertions assume that `out_slot` never arrives while a fetch is still pending. This requires the slot spacing to exceed `MAX_WAIT` plus the cycles `mem_ready` is held low. They also assume that a pointer preset and a dummy read do not fall in the same cycle. The bench spaces slots eight cycles apart with `MAX_WAIT` of 4 and keeps `mem_ready` high whenever slots run. It drives a continuous write burst during playback so that the promotion path is exercised. Register accesses are issued one at a time.

// File: rtl/shockbuf_ctrl.sv
module shockbuf_ctrl #(
  parameter int SYMS     = 32,
  parameter int NFRM     = 16,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_sym,
  input  logic              in_err,
  output logic              in_ready,
  input  logic              out_slot,
  output logic              out_valid,
  output logic [DW-1:0]     out_sym,
  output logic              out_invalid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [$clog2(NFRM)+$clog2(SYMS)-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ovf_irq
);
  localparam int SW = $clog2(SYMS);
  localparam int FW = $clog2(NFRM);
  localparam int CW = $clog2(MAX_WAIT + 1);

  logic [FW-1:0] wp, rp, last_ok;
  logic [SW-1:0] wsym, rsym;
  logic [CW-1:0] rd_wait;
  logic [DW-1:0] hold_sym;
  logic [7:0]    pre_lo;
  logic          drop_q, err_q, rd_pend, rd_ack, hold_inv;

  wire [FW-1:0] level   = wp - rp;
  wire          clr     = reg_rd && reg_addr == 3'd6;
  wire          preset  = reg_wr && reg_addr == 3'd1;
  wire          first   = wsym == '0;
  wire          last_w  = wsym == SW'(SYMS - 1);
  wire          last_r  = rsym == SW'(SYMS - 1);
  wire          drop_now = first ? (level == {FW{1'b1}}) : drop_q;
  wire          promote = rd_pend && rd_wait == CW'(MAX_WAIT);
  wire          wr_want = in_valid && !drop_now && !promote;
  wire          rd_go   = rd_pend && mem_ready && !wr_want;
  wire          take    = in_valid && in_ready;

  assign in_ready  = drop_now || (mem_ready && !promote);
  assign mem_req   = wr_want || rd_pend;
  assign mem_we    = wr_want;
  assign mem_addr  = wr_want ? {wp, wsym} : {rp, rsym};
  assign mem_wdata = in_sym;

  wire [15:0] wp16   = 16'(wp);
  wire [15:0] last16 = 16'(last_ok);
  wire [15:0] lvl16  = 16'(level);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = wp16[7:0];
      3'd1:    reg_rdata = wp16[15:8];
      3'd2:    reg_rdata = last16[7:0];
      3'd3:    reg_rdata = last16[15:8];
      3'd4:    reg_rdata = lvl16[7:0];
      3'd5:    reg_rdata = lvl16[15:8];
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; last_ok <= '0;
      wsym <= '0; rsym <= '0; rd_wait <= '0;
      hold_sym <= '0; hold_inv <= 1'b1; pre_lo <= '0;
      drop_q <= 1'b0; err_q <= 1'b0; rd_pend <= 1'b0; rd_ack <= 1'b0;
      out_valid <= 1'b0; out_sym <= '0; out_invalid <= 1'b0;
      ovf_irq <= 1'b0;
    end else begin
      if (take) begin
        wsym  <= wsym + 1'b1;
        err_q <= first ? in_err : (err_q || in_err);
        if (first) begin
          drop_q <= drop_now;
          if (drop_now) ovf_irq <= 1'b1;
        end
        if (last_w && !drop_now) begin
          wp <= wp + 1'b1;
          if (!(err_q || in_err)) last_ok <= wp;
        end
      end
      if (reg_wr && reg_addr == 3'd0) pre_lo <= reg_wdata;
      if (preset) begin
        wp   <= FW'({reg_wdata, pre_lo});
        wsym <= '0;
      end

      out_valid <= out_slot;
      if (out_slot) begin
        out_sym     <= hold_sym;
        out_invalid <= hold_inv;
        if (level == '0) begin
          hold_inv <= 1'b1;
          hold_sym <= '0;
        end else begin
          rd_pend <= 1'b1;
        end
      end
      if (rd_pend) begin
        if (rd_go) begin
          rd_pend <= 1'b0;
          rd_wait <= '0;
          rsym    <= rsym + 1'b1;
          if (last_r) rp <= rp + 1'b1;
        end else if (!promote) begin
          rd_wait <= rd_wait + 1'b1;
        end
      end
      rd_ack <= rd_go;
      if (rd_ack) begin
        hold_sym <= mem_rdata;
        hold_inv <= 1'b0;
      end

      if (clr) begin
        wp <= '0; rp <= '0; wsym <= '0; rsym <= '0;
        drop_q <= 1'b0; err_q <= 1'b0;
        rd_pend <= 1'b0; rd_wait <= '0; ovf_irq <= 1'b0;
      end
    end
  end
endmodule

module shockbuf_ctrl_chk #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_slot,
  input logic          out_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic          promote,
  input logic          rd_pend,
  input logic [FW-1:0] level,
  input logic          ovf_irq,
  input logic          clr,
  input logic          preset
);
  p_slot_delivers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_slot |=> out_valid);
  p_valid_needs_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_slot));
  p_promoted_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (promote && mem_ready) |-> (mem_req && !mem_we));
  p_slot_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_slot |-> !rd_pend);
  p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && !$past(preset)) |->
      (level == $past(level) || level == FW'($past(level) + 1'b1) ||
       level == FW'($past(level) - 1'b1)));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !clr) |=> ovf_irq);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !preset) |=> (level == '0 && !ovf_irq));
endmodule

bind shockbuf_ctrl shockbuf_ctrl_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_slot(out_slot), .out_valid(out_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .promote(promote), .rd_pend(rd_pend), .level(level), .ovf_irq(ovf_irq),
  .clr(clr), .preset(preset)
);

// File: tb/sim_shockbuf_ctrl.sv
`timescale 1ns/1ps
module sim_shockbuf_ctrl;
  localparam int SYMS = 32;
  localparam int NFRM = 16;
  localparam int AW   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_err = 1'b0, in_ready;
  logic [7:0] in_sym = '0;
  logic out_slot = 1'b0, out_valid, out_invalid;
  logic [7:0] out_sym;
  logic mem_req, mem_we, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ovf_irq;

  always #10 clk = ~clk;

  shockbuf_ctrl #(.SYMS(SYMS), .NFRM(NFRM), .DW(8), .MAX_WAIT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .in_err(in_err), .in_ready(in_ready), .out_slot(out_slot),
    .out_valid(out_valid), .out_sym(out_sym), .out_invalid(out_invalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_irq(ovf_irq));

  logic [7:0] mem [2**AW];
  logic [7:0] rdq = '0;
  assign mem_rdata = rdq;
  always @(posedge clk)
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else rdq <= mem[mem_addr];
    end

  logic slot_en = 1'b0;
  logic [2:0] sc = '0;
  always @(negedge clk)
    if (slot_en) begin
      sc <= sc + 1'b1;
      out_slot <= (sc == 3'd0);
    end else begin
      sc <= '0;
      out_slot <= 1'b0;
    end

  logic [7:0] cap_sym [512];
  logic       cap_inv [512];
  int ncap = 0;
  always @(negedge clk)
    if (out_valid && ncap < 512) begin
      cap_sym[ncap] = out_sym;
      cap_inv[ncap] = out_invalid;
      ncap++;
    end

  int ntest = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] base, input logic err);
    for (int k = 0; k < SYMS; k++) begin
      int tries;
      logic acc;
      tries = 0;
      in_valid = 1'b1;
      in_sym = base + 8'(k);
      in_err = err && (k == 5);
      do begin
        #1 acc = in_ready;
        @(posedge clk);
        @(negedge clk);
        tries++;
      end while (!acc && tries < 200);
    end
    in_valid = 1'b0;
    in_err = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    reg_read(lo, l);
    reg_read(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic mem_frame(input string tag, input int slot, input logic [7:0] base);
    int bad;
    bad = 0;
    for (int k = 0; k < SYMS; k++)
      if (mem[slot*SYMS + k] !== base + 8'(k)) bad++;
    chk(tag, bad, 0);
  endtask

  // {err, base, expected last-valid slot}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 8'h10, 4'd0}, {1'b0, 8'h40, 4'd1}, {1'b0, 8'h77, 4'd2},
    {1'b1, 8'hA0, 4'd2}, {1'b0, 8'h03, 4'd4}, {1'b0, 8'hC8, 4'd5},
    {1'b1, 8'h5A, 4'd5}, {1'b0, 8'hE1, 4'd7}};

  initial begin
    repeat (100000) @(posedge clk);
    ntest++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic [7:0]  fb [12];
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd16(3'd4, v);  chk("R1 level after reset", v, 0);
    rd16(3'd2, v);  chk("R1 last-valid after reset", v, 0);
    chk("R1 ovf_irq after reset", ovf_irq, 0);
    #1 chk("R3 in_ready with memory ready", in_ready, 1);
    @(negedge clk);
    mem_ready = 1'b0;
    #1 chk("R3 in_ready stalls when memory busy", in_ready, 0);
    @(negedge clk);
    mem_ready = 1'b1;

    for (int i = 0; i < 8; i++) begin
      send_frame(VEC[i][11:4], VEC[i][12]);
      fb[i] = VEC[i][11:4];
      rd16(3'd4, v);  chk($sformatf("R5 level after frame %0d", i), v, i + 1);
      rd16(3'd2, v);  chk($sformatf("R7 last-valid after frame %0d", i), v, VEC[i][3:0]);
      mem_frame($sformatf("R4 frame %0d stored", i), i, VEC[i][11:4]);
    end

    for (int i = 8; i < 12; i++) fb[i] = 8'(i * 19);
    slot_en = 1'b1;
    for (int i = 8; i < 12; i++) send_frame(fb[i], 1'b0);
    wait (ncap >= 388);
    @(negedge clk);
    slot_en = 1'b0;
    repeat (12) @(negedge clk);

    chk("R1 first delivered symbol invalid", cap_inv[0], 1);
    for (int f = 0; f < 12; f++) begin
      int bad;
      bad = 0;
      for (int k = 0; k < SYMS; k++)
        if (cap_inv[1 + f*SYMS + k] !== 1'b0 || cap_sym[1 + f*SYMS + k] !== fb[f] + 8'(k))
          bad++;
      chk($sformatf("R2 R3 playback of frame %0d", f), bad, 0);
    end
    for (int j = 385; j < 388; j++) begin
      chk($sformatf("R8 underflow flag at %0d", j), cap_inv[j], 1);
      chk($sformatf("R8 underflow symbol at %0d", j), cap_sym[j], 0);
    end
    rd16(3'd4, v);  chk("R5 level after playback", v, 0);

    reg_read(3'd6, b);  chk("R10 dummy read data", b, 0);
    reg_read(3'd0, b);  chk("R10 write pointer cleared", b, 0);

    for (int i = 0; i < 15; i++) send_frame(8'(i * 7), 1'b0);
    rd16(3'd4, v);  chk("R6 level at full", v, 15);
    chk("R6 no overflow yet", ovf_irq, 0);
    mem_ready = 1'b0;
    send_frame(8'h55, 1'b0);
    mem_ready = 1'b1;
    chk("R6 overflow interrupt", ovf_irq, 1);
    rd16(3'd4, v);  chk("R6 level unchanged by dropped frame", v, 15);
    rd16(3'd2, v);  chk("R6 R7 last-valid unchanged by dropped frame", v, 14);
    reg_read(3'd6, b);
    @(negedge clk);
    chk("R10 overflow cleared", ovf_irq, 0);
    rd16(3'd4, v);  chk("R10 level cleared", v, 0);

    reg_write(3'd0, 8'h03);
    reg_write(3'd1, 8'h00);
    reg_read(3'd0, b);  chk("R9 preset read back", b, 3);
    rd16(3'd4, v);  chk("R9 level after preset", v, 3);
    send_frame(8'h90, 1'b0);
    mem_frame("R9 R4 frame at preset slot", 3, 8'h90);
    rd16(3'd4, v);  chk("R9 level after preset frame", v, 4);
    rd16(3'd2, v);  chk("R9 R7 last-valid at preset slot", v, 3);

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule